// File: doc/BRIEF.md
# Grouped Presence-Vector Coherence Directory

This block is the home-side directory for a small shared-memory multiprocessor. For every tracked line it keeps a coherence state and a presence vector. Each presence bit stands for a group of `GRP` consecutive processors, so the vector is `NPROC/GRP` bits wide. With `GRP = 1` the vector has one bit per processor and is exact. With larger groups a set bit means only that some member of the group may hold the line.

Caches send read-miss and write-miss requests, each tagged with the processor number. A read miss is handled in the accepting cycle, and its grant follows one cycle later.

A write miss is handled in one of two ways:
- If no other group is marked, it completes just like a read.
- Otherwise the directory emits one invalidation for every processor of every other marked group. The invalidations leave one per cycle, on a valid/ready stream, in ascending processor order. This includes group members that never fetched the line. The directory then waits until it has counted as many acknowledgements as invalidations sent. Only then does it record the requester's group as the sole holder, in state Modified, and issue the grant.

Both streams follow the same back-pressure rules:
- Request stream: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole of an invalidating write, which stalls every further request, including requests to the same line.
- Invalidation stream: once `inv_valid` rises, it stays high and `inv_pid` stays stable until `inv_ready` is seen high.

Acknowledgements are single-cycle pulses with no back-pressure. Grants are single-cycle pulses. The processor count must be a multiple of the group size, and elaboration stops with an error otherwise.

Top module: `grp_sharer_dir`

## Requirements
- R1: After reset every line is Uncached with an all-zero presence vector; `req_ready` is high and `inv_valid` and `grant_valid` are low.
- R2: State codes on `grant_state` are 0 Uncached, 1 Shared, 2 Exclusive, 3 Modified. The group of processor p is p / GRP, and that group owns bit (p / GRP) of the vector.
- R3: A read miss on a line where no group other than the requester's is marked grants state 2, or keeps state 3 if the line was already 3. The vector becomes the old vector OR the requester's bit. `grant_valid` is high in the cycle after acceptance.
- R4: A read miss on a line where another group is marked grants state 1. The vector becomes the old vector OR the requester's bit. The grant is due in the cycle after acceptance.
- R5: A write miss on a line where no other group is marked sends no invalidation. In the cycle after acceptance it grants state 3 with only the requester's bit set.
- R6: A write miss on a line with other groups marked emits exactly one invalidation for every processor whose group is marked and differs from the requester's group. The invalidations leave in ascending processor order, at most one per cycle, with the target on `inv_pid`.
- R7: While `inv_valid` is high and `inv_ready` is low, `inv_valid` stays high and `inv_pid` holds its value in the next cycle.
- R8: The grant of an invalidating write comes only after the count of `ack_valid` pulses equals the number of invalidations accepted. It reports state 3 and a vector with only the requester's bit.
- R9: `req_ready` is low from the acceptance of an invalidating write until its grant cycle. `ack_valid` pulses while no write is waiting are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_line | input | LW | Line index |
| req_pid | input | PW | Requesting processor |
| inv_valid | output | 1 | Invalidation present |
| inv_ready | input | 1 | Invalidation taken by the network |
| inv_pid | output | PW | Processor to invalidate |
| ack_valid | input | 1 | One invalidation acknowledgement this cycle |
| grant_valid | output | 1 | Grant pulse |
| grant_line | output | LW | Line of the grant |
| grant_pid | output | PW | Processor receiving the grant |
| grant_state | output | 2 | New state of the line |
| grant_vec | output | NGRP | New presence vector of the line |

## Verification
Read misses and write misses that need no invalidation must raise the grant exactly one cycle after the accepting edge. The bench therefore samples `grant_valid` and its fields at the first falling edge after acceptance. For an invalidating write, the bench compares each invalidation with its own ascending target list on the falling edge before the edge that takes it. It returns acknowledgements either interleaved with the invalidations or after all of them. It then checks that the grant, whenever it appears, comes with the full acknowledgement count and that `req_ready` stayed low on every cycle before it.

// File: rtl/dirc_pkg.sv
package dirc_pkg;
  typedef enum logic [1:0] {
    LS_UNC = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_st_t;
endpackage

// File: rtl/dirc_entry_store.sv
module dirc_entry_store
  import dirc_pkg::*;
#(
  parameter int unsigned NLINES = 4,
  parameter int unsigned NGRP   = 4,
  parameter int unsigned LW     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LW-1:0]   rd_line,
  output line_st_t        rd_st,
  output logic [NGRP-1:0] rd_vec,
  input  logic            wr_en,
  input  logic [LW-1:0]   wr_line,
  input  line_st_t        wr_st,
  input  logic [NGRP-1:0] wr_vec
);
  line_st_t        st_q  [NLINES];
  logic [NGRP-1:0] vec_q [NLINES];

  for (genvar i = 0; i < NLINES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[i]  <= LS_UNC;
        vec_q[i] <= '0;
      end else if (wr_en && (wr_line == LW'(i))) begin
        st_q[i]  <= wr_st;
        vec_q[i] <= wr_vec;
      end
    end
  end

  always_comb begin
    rd_st  = LS_UNC;
    rd_vec = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (rd_line == LW'(i)) begin
        rd_st  = st_q[i];
        rd_vec = vec_q[i];
      end
    end
  end
endmodule

// File: rtl/dirc_update.sv
module dirc_update
  import dirc_pkg::*;
#(
  parameter int unsigned NGRP = 4,
  parameter int unsigned GW   = 2
) (
  input  logic            is_write,
  input  line_st_t        old_st,
  input  logic [NGRP-1:0] old_vec,
  input  logic [GW-1:0]   grp,
  output line_st_t        new_st,
  output logic [NGRP-1:0] new_vec,
  output logic [NGRP-1:0] others
);
  logic [NGRP-1:0] own;

  always_comb begin
    own    = NGRP'(1) << grp;
    others = old_vec & ~own;
    if (is_write) begin
      new_vec = own;
      new_st  = LS_MOD;
    end else begin
      new_vec = old_vec | own;
      if (|others)               new_st = LS_SHR;
      else if (old_st == LS_MOD) new_st = LS_MOD;
      else                       new_st = LS_EXC;
    end
  end
endmodule

// File: rtl/dirc_inv_seq.sv
module dirc_inv_seq #(
  parameter int unsigned NPROC = 8,
  parameter int unsigned GRP   = 2,
  parameter int unsigned NGRP  = 4,
  parameter int unsigned PW    = 3,
  parameter int unsigned CW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NGRP-1:0] targets,
  input  logic            finish,
  output logic            inv_valid,
  input  logic            inv_ready,
  output logic [PW-1:0]   inv_pid,
  input  logic            ack_valid,
  output logic            acks_met
);
  localparam logic [PW-1:0] LAST_P = PW'(NPROC - 1);

  logic [PW-1:0]   ptr;
  logic [NGRP-1:0] tgt;
  logic            active, scanned;
  logic [CW-1:0]   sent, acks;
  logic [PW-1:0]   gidx;
  logic            hit, adv;

  always_comb begin
    gidx = ptr / PW'(GRP);
    hit  = 1'b0;
    for (int g = 0; g < NGRP; g++)
      if (gidx == PW'(g)) hit = tgt[g];
  end

  assign inv_valid = active && hit;
  assign inv_pid   = ptr;
  assign adv       = active && (!hit || inv_ready);
  assign acks_met  = scanned && (acks == sent);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      tgt     <= '0;
      active  <= 1'b0;
      scanned <= 1'b0;
      sent    <= '0;
      acks    <= '0;
    end else if (start) begin
      ptr     <= '0;
      tgt     <= targets;
      active  <= 1'b1;
      scanned <= 1'b0;
      sent    <= '0;
      acks    <= '0;
    end else begin
      if (adv) begin
        if (ptr == LAST_P) begin
          active  <= 1'b0;
          scanned <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
      if (inv_valid && inv_ready) sent <= sent + 1'b1;
      if (ack_valid && (active || scanned)) acks <= acks + 1'b1;
      if (finish) scanned <= 1'b0;
    end
  end
endmodule

// File: rtl/grp_sharer_dir.sv
module grp_sharer_dir
  import dirc_pkg::*;
#(
  parameter int unsigned NPROC  = 8,
  parameter int unsigned GRP    = 2,
  parameter int unsigned NLINES = 4,
  localparam int unsigned NGRP  = NPROC / GRP,
  localparam int unsigned PW    = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int unsigned GW    = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int unsigned LW    = (NLINES > 1) ? $clog2(NLINES) : 1,
  localparam int unsigned CW    = $clog2(NPROC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [LW-1:0]   req_line,
  input  logic [PW-1:0]   req_pid,
  output logic            inv_valid,
  input  logic            inv_ready,
  output logic [PW-1:0]   inv_pid,
  input  logic            ack_valid,
  output logic            grant_valid,
  output logic [LW-1:0]   grant_line,
  output logic [PW-1:0]   grant_pid,
  output logic [1:0]      grant_state,
  output logic [NGRP-1:0] grant_vec
);
  if ((NPROC % GRP) != 0) begin : g_bad_cfg
    $error("grp_sharer_dir: NPROC must be a multiple of GRP");
  end

  logic            busy;
  logic [LW-1:0]   cur_line;
  logic [PW-1:0]   cur_pid;
  logic [LW-1:0]   sel_line;
  logic [PW-1:0]   sel_pid;
  logic [PW-1:0]   sel_q;
  logic [GW-1:0]   sel_grp;
  logic            sel_write;
  line_st_t        old_st, new_st;
  logic [NGRP-1:0] old_vec, new_vec, others;
  logic            accept, acks_met, start, wr_en, finish;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign sel_line  = busy ? cur_line : req_line;
  assign sel_pid   = busy ? cur_pid  : req_pid;
  assign sel_write = busy ? 1'b1     : req_write;
  assign sel_q     = sel_pid / PW'(GRP);
  assign sel_grp   = GW'(sel_q);

  dirc_entry_store #(.NLINES(NLINES), .NGRP(NGRP), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_line(sel_line), .rd_st(old_st), .rd_vec(old_vec),
    .wr_en(wr_en), .wr_line(sel_line), .wr_st(new_st), .wr_vec(new_vec)
  );

  dirc_update #(.NGRP(NGRP), .GW(GW)) u_upd (
    .is_write(sel_write), .old_st(old_st), .old_vec(old_vec), .grp(sel_grp),
    .new_st(new_st), .new_vec(new_vec), .others(others)
  );

  assign start  = accept && req_write && (|others);
  assign finish = busy && acks_met;
  assign wr_en  = (accept && !start) || finish;

  dirc_inv_seq #(.NPROC(NPROC), .GRP(GRP), .NGRP(NGRP), .PW(PW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .targets(others), .finish(finish),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_pid(inv_pid),
    .ack_valid(ack_valid), .acks_met(acks_met)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cur_line    <= '0;
      cur_pid     <= '0;
      grant_valid <= 1'b0;
      grant_line  <= '0;
      grant_pid   <= '0;
      grant_state <= 2'd0;
      grant_vec   <= '0;
    end else begin
      grant_valid <= wr_en;
      if (start) begin
        busy     <= 1'b1;
        cur_line <= req_line;
        cur_pid  <= req_pid;
      end
      if (finish) busy <= 1'b0;
      if (wr_en) begin
        grant_line  <= sel_line;
        grant_pid   <= sel_pid;
        grant_state <= new_st;
        grant_vec   <= new_vec;
      end
    end
  end
endmodule

// File: rtl/dirc_checker.sv
module dirc_checker #(
  parameter int unsigned GRP  = 2,
  parameter int unsigned NGRP = 4,
  parameter int unsigned PW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            inv_valid,
  input logic            inv_ready,
  input logic [PW-1:0]   inv_pid,
  input logic [PW-1:0]   cur_pid,
  input logic            grant_valid,
  input logic [1:0]      grant_state,
  input logic [NGRP-1:0] grant_vec
);
  p_inv_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_pid));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !req_ready);

  p_no_self_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> ((int'(inv_pid) / GRP) != (int'(cur_pid) / GRP)));

  p_owner_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && (grant_state >= 2'd2) |-> ($countones(grant_vec) == 1));

  p_shared_multi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && (grant_state == 2'd1) |-> ($countones(grant_vec) >= 2));

  p_grant_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !inv_valid);
endmodule

bind grp_sharer_dir dirc_checker #(.GRP(GRP), .NGRP(NGRP), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_pid(inv_pid),
  .cur_pid(cur_pid), .grant_valid(grant_valid),
  .grant_state(grant_state), .grant_vec(grant_vec)
);

// File: tb/grp_sharer_dir_bench.sv
module grp_sharer_dir_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int GS = 2;
  localparam int NG = NP / GS;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_line = '0;
  logic [2:0] req_pid = '0;
  logic inv_ready = 1'b0, ack_valid = 1'b0;
  logic req_ready, inv_valid, grant_valid;
  logic [2:0] inv_pid, grant_pid;
  logic [1:0] grant_line, grant_state;
  logic [NG-1:0] grant_vec;

  int checks = 0;
  int fails  = 0;
  int mst  [NL];
  int mvec [NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  grp_sharer_dir #(.NPROC(NP), .GRP(GS), .NLINES(NL)) u_grp_sharer_dir (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_line(req_line), .req_pid(req_pid),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_pid(inv_pid),
    .ack_valid(ack_valid),
    .grant_valid(grant_valid), .grant_line(grant_line), .grant_pid(grant_pid),
    .grant_state(grant_state), .grant_vec(grant_vec)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check_grant(input string req, input int line, input int pid,
                             input int st, input int vec);
    chk({req, " grant_valid"}, int'(grant_valid), 1);
    chk({req, " grant_line"}, int'(grant_line), line);
    chk({req, " grant_pid"}, int'(grant_pid), pid);
    chk({req, " grant_state"}, int'(grant_state), st);
    chk({req, " grant_vec"}, int'(grant_vec), vec);
  endtask

  // one transaction; caller is at a falling edge with the directory idle
  task automatic transact(input int line, input int pid, input bit wr, input int mode);
    int own, oth, ns, nv, n_exp, k, acks, pending, guard;
    int exp_list [NP];
    own = 1 << (pid / GS);
    oth = mvec[line] & ~own;
    chk("R9 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_line = 2'(line); req_pid = 3'(pid);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) begin
      nv = mvec[line] | own;
      if (oth != 0) ns = 1;
      else if (mst[line] == 3) ns = 3;
      else ns = 2;
      check_grant((oth != 0) ? "R4 shared read" : "R3 sole read", line, pid, ns, nv);
      mst[line] = ns; mvec[line] = nv;
    end else if (oth == 0) begin
      chk("R5 no invalidation", int'(inv_valid), 0);
      check_grant("R5 quiet write", line, pid, 3, own);
      mst[line] = 3; mvec[line] = own;
    end else begin
      n_exp = 0;
      for (int p = 0; p < NP; p++)
        if (((oth >> (p / GS)) & 1) != 0) begin
          exp_list[n_exp] = p;
          n_exp++;
        end
      k = 0; acks = 0; pending = 0; guard = 0;
      chk("R9 no early grant", int'(grant_valid), 0);
      while (!grant_valid && guard < 300) begin
        chk("R9 ready low while invalidating", int'(req_ready), 0);
        inv_ready = ((guard % 3) != 1);
        if (inv_valid) begin
          if (k < n_exp) chk("R6 invalidation target", int'(inv_pid), exp_list[k]);
          else chk("R6 invalidation count", k + 1, n_exp);
          if (inv_ready) begin k++; pending++; end
        end
        if (mode == 1) ack_valid = (pending > 0) && ((guard % 2) == 0);
        else ack_valid = (k == n_exp) && (pending > 0) && !inv_valid;
        if (ack_valid) begin pending--; acks++; end
        guard++;
        @(negedge clk);
      end
      inv_ready = 1'b0;
      ack_valid = 1'b0;
      chk("R6 invalidations sent", k, n_exp);
      chk("R8 acks before grant", acks, n_exp);
      check_grant("R8 invalidating write", line, pid, 3, own);
      mst[line] = 3; mvec[line] = own;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int l = 0; l < NL; l++) begin mst[l] = 0; mvec[l] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 req_ready after reset", int'(req_ready), 1);
    chk("R1 inv_valid after reset", int'(inv_valid), 0);
    chk("R1 grant_valid after reset", int'(grant_valid), 0);
    // R1/R2: each untouched line reads back as Uncached: a read grants state 2 with only own bit
    for (int l = 0; l < NL; l++) transact(l, l * 2 + 1, 1'b0, 0);
    // sweep: many processors, read/write mixes, both ack modes
    for (int i = 0; i < 160; i++) begin
      int line, pid;
      bit wr;
      line = i % NL;
      pid  = (i * 3 + i / 4 + i / 16) % NP;
      wr   = ((i % 5) == 2) || ((i % 7) == 6);
      if ((i % 6) == 0) begin
        // R9: stray acknowledgements while idle must not count toward a later write
        ack_valid = 1'b1; @(negedge clk); @(negedge clk); ack_valid = 1'b0;
      end
      transact(line, pid, wr, i % 2);
    end
    // R3: owner re-reading a Modified line keeps Modified
    transact(0, 4, 1'b1, 0);
    transact(0, 5, 1'b0, 0);
    // R6: widest fan-out: every group marked, then a write
    for (int p = 0; p < NP; p += GS) transact(1, p, 1'b0, 0);
    ack_valid = 1'b1; @(negedge clk); ack_valid = 1'b0;
    transact(1, 7, 1'b1, 1);
    transact(1, 6, 1'b1, 0);
    summary();
  end
endmodule